// File: doc/BRIEF.md
# Edge-Latched Inverting Word Memory

A small read/write memory of 16 words, each 4 bits wide. It has an active-low select and an active-low write strobe. All inputs are sampled on the rising edge of a system clock. An access starts only when the select input goes from high to low. In that cycle the address inputs are captured into an internal register, and that captured address serves the whole access. Any address change after the edge is ignored until the select goes high and falls again.

While the select is low and the write strobe is high, the block reads: it presents the bitwise inverse of the selected word and raises an output-enable flag. While both are low, it stores the data inputs into the captured word, and the output stays undriven. With the select high, the contents are kept and the output floats. The output is a data word plus an enable flag that an external tri-state buffer can use. When the flag is low, the data word is forced to zero.

Within one low period of the select, a read may be followed by a write to the same captured word, giving a read-modify-write. After a write, the read data comes straight from the array, so it shows the new contents as soon as the write strobe returns high.

Top module: `edge_latched_inv_ram`

## Requirements
- R1: Every one of the 16 words, chosen by the 4-bit address, keeps its own 4-bit value, and that value can be read back independently of the other words.
- R2: The address is captured in the clock cycle in which the select falls. Address changes later in the same low period change neither the word read nor the word written.
- R3: With select low and write strobe high, outEn is 1 and dataOut equals the bitwise inverse of the stored word. The result is visible in the same cycle in which the falling edge is detected.
- R4: With select low and write strobe low, dataIn is stored into the captured word at the clock edge, and outEn is 0.
- R5: With select high, no word changes, whatever the write strobe and data inputs do, and outEn is 0.
- R6: Reading is non-destructive. Repeated reads of one word return the same inverted value.
- R7: If the select is held low since reset with no falling edge, no access happens: outEn stays 0 and writes are not performed.
- R8: Within one low period, a read followed by a write and a further read of the same captured word returns the inverse of the newly written value.
- R9: Whenever outEn is 0, dataOut is all zeros.
- R10: A synchronous active-high reset clears the edge history and the captured-address valid state, ending any access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| selN | input | 1 | Memory select, active low; its falling edge starts an access |
| wrN | input | 1 | Write strobe, active low |
| addrIn | input | 4 | Word address, captured on the select falling edge |
| dataIn | input | 4 | Write data |
| dataOut | output | 4 | Inverted read data, zero when not driven |
| outEn | output | 1 | High while read data is valid for the tri-state driver |

## Verification
Two events can land in the same cycle: the address capture on the select's falling edge, and the read or write that uses that address. The bench provokes this by driving the new address in the very cycle the select falls. It expects the read value, or the write, to belong to that new address, not to the one captured earlier. A second collision is a write followed by a read within one low period while the address inputs wander. Here the read must show the inverse of the new data for the captured word, and the bench confirms that the word the wandering address pointed to is left untouched.

// File: rtl/eli_ram_pkg.sv
package eli_ram_pkg;
  // Strobes passed from the access control to the storage datapath
  typedef struct packed {
    logic wrEn;   // store dataIn at the access address this edge
    logic rdEn;   // present inverted word and raise output enable
  } accStrobe_t;
endpackage

// File: rtl/eli_ram_ctrl.sv
module eli_ram_ctrl
  import eli_ram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addrIn,
  output accStrobe_t        strb,
  output logic [ADDR_W-1:0] accAddr
);

  logic              selDly;
  logic              addrValid;
  logic [ADDR_W-1:0] heldAddr;
  logic              fallDet;
  logic              accValid;

  // Falling edge of select: previous sample high, current sample low
  assign fallDet  = selDly & ~selN;
  assign accValid = fallDet | addrValid;
  assign accAddr  = fallDet ? addrIn : heldAddr;

  always_comb begin
    strb.wrEn = ~selN & ~wrN & accValid;
    strb.rdEn = ~selN &  wrN & accValid;
  end

  // Reset treats select as already low, so a low select after reset is not an edge
  always_ff @(posedge clk) begin
    if (rst) begin
      selDly    <= 1'b0;
      addrValid <= 1'b0;
    end else begin
      selDly <= selN;
      if (selN)
        addrValid <= 1'b0;
      else if (fallDet)
        addrValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fallDet)
      heldAddr <= addrIn;
  end

  // R2: once captured, the address holds for the rest of the low period
  p_addr_held_r2: assert property (@(posedge clk) disable iff (rst)
    (addrValid && !selN && !fallDet) |=> $stable(heldAddr));

  // R5: a high select ends any access at the next edge
  p_sel_high_ends_r5: assert property (@(posedge clk) disable iff (rst)
    selN |=> !addrValid);

  // R4: read and write strobes never coincide
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(strb.wrEn && strb.rdEn));

endmodule

// File: rtl/eli_ram_datapath.sv
module eli_ram_datapath
  import eli_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  accStrobe_t        strb,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];
  logic [DATA_W-1:0] rdWord;

  // Storage has no reset; contents are undefined until written
  always_ff @(posedge clk) begin
    for (int w = 0; w < DEPTH; w++) begin
      if (strb.wrEn && accAddr == ADDR_W'(w))
        words[w] <= dataIn;
    end
  end

  assign rdWord  = words[accAddr];
  assign outEn   = strb.rdEn;
  assign dataOut = strb.rdEn ? ~rdWord : '0;

  // R4: a write strobe lands the data in the addressed word
  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    strb.wrEn |=> words[$past(accAddr)] == $past(dataIn));

  // R9: undriven output carries zeros
  p_float_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.rdEn |-> dataOut == '0);

endmodule

// File: rtl/edge_latched_inv_ram.sv
module edge_latched_inv_ram
  import eli_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outEn
);

  accStrobe_t        strb;
  logic [ADDR_W-1:0] accAddr;

  eli_ram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .selN    (selN),
    .wrN     (wrN),
    .addrIn  (addrIn),
    .strb    (strb),
    .accAddr (accAddr)
  );

  eli_ram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .accAddr (accAddr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .outEn   (outEn)
  );

  // R4: the output floats while writing
  p_float_on_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!selN && !wrN) |-> !outEn);

  // R5: the output floats while deselected
  p_float_on_inhibit_r5: assert property (@(posedge clk) disable iff (rst)
    selN |-> !outEn);

endmodule

// File: tb/sim_edge_latched_inv_ram.sv
module sim_edge_latched_inv_ram;

  logic       clk = 1'b0;
  logic       rst;
  logic       selN, wrN;
  logic [3:0] addrIn, dataIn;
  logic [3:0] dataOut;
  logic       outEn;

  int checks = 0;
  int errors = 0;

  edge_latched_inv_ram u0 (
    .clk(clk), .rst(rst), .selN(selN), .wrN(wrN),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .outEn(outEn)
  );

  always #2 clk = ~clk;   // 250 MHz

  function automatic logic [3:0] patA(int a);
    return 4'((a * 5 + 3) & 15);
  endfunction
  function automatic logic [3:0] patB(int a);
    return 4'((a * 11 + 6) & 15);
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive after the falling clock edge, then settle 1 ns before the rising edge
  task automatic step(logic s, logic w, logic [3:0] a, logic [3:0] d);
    @(negedge clk);
    selN = s; wrN = w; addrIn = a; dataIn = d;
    #1;
  endtask

  task automatic wrWord(int a, logic [3:0] d);
    step(1, 1, 4'h0, 4'h0);
    step(0, 0, 4'(a), d);
    chk("R4 outEn during write", {3'b0, outEn}, 4'h0);
    chk("R9 dataOut zero on write", dataOut, 4'h0);
    step(1, 1, 4'h0, 4'h0);
  endtask

  task automatic rdWord(int a, logic [3:0] exp, bit wander);
    step(1, 1, 4'h0, 4'h0);
    step(0, 1, 4'(a), 4'h0);
    chk("R3 outEn on read", {3'b0, outEn}, 4'h1);
    chk("R1 R3 inverted word", dataOut, ~exp);
    if (wander) begin
      step(0, 1, 4'(a) ^ 4'hF, 4'h0);
      chk("R2 address held", dataOut, ~exp);
      step(0, 1, 4'(a) + 4'h1, 4'h0);
      chk("R6 repeated read", dataOut, ~exp);
    end
    step(1, 1, 4'(a), 4'h0);
    chk("R5 outEn off when deselected", {3'b0, outEn}, 4'h0);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; selN = 1'b0; wrN = 1'b1; addrIn = 4'h0; dataIn = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: select low since reset, no falling edge
    step(0, 1, 4'h3, 4'h0);
    chk("R7 no access without edge", {3'b0, outEn}, 4'h0);
    chk("R9 zero output at reset", dataOut, 4'h0);

    // R1: two full sweeps of all words
    for (int a = 0; a < 16; a++) wrWord(a, patA(a));
    for (int a = 0; a < 16; a++) rdWord(a, patA(a), 1'b1);
    for (int a = 0; a < 16; a++) wrWord(a, patB(a));
    for (int a = 0; a < 16; a++) rdWord(a, patB(a), 1'b0);

    // R5: inhibited cycles with write strobe low and varying data
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 4'(i), 4'(~i));
      chk("R5 outEn off inhibited", {3'b0, outEn}, 4'h0);
    end
    for (int a = 0; a < 8; a++) rdWord(a, patB(a), 1'b0);

    // R2: address wanders during a write; only the captured word changes
    step(1, 1, 4'h0, 4'h0);
    step(0, 0, 4'h5, 4'hC);
    step(0, 0, 4'h6, 4'h3);   // still word 5, data 3
    step(1, 1, 4'h0, 4'h0);
    rdWord(5, 4'h3, 1'b0);
    rdWord(6, patB(6), 1'b0);

    // R8: read-modify-write within one low period
    step(1, 1, 4'h0, 4'h0);
    step(0, 1, 4'h9, 4'h0);
    chk("R8 read before modify", dataOut, ~patB(9));
    step(0, 0, 4'hA, ~patB(9) ^ 4'h5);
    chk("R8 float while writing", {3'b0, outEn}, 4'h0);
    step(0, 1, 4'hB, 4'h0);
    chk("R8 read after modify", dataOut, patB(9) ^ 4'h5);
    step(1, 1, 4'h0, 4'h0);
    rdWord(10, patB(10), 1'b0);

    // R10: reset in the middle of a read, then select stays low with writes
    step(1, 1, 4'h0, 4'h0);
    step(0, 1, 4'h2, 4'h0);
    chk("R3 read before reset", dataOut, ~patB(2));
    @(negedge clk); rst = 1'b1;
    step(0, 1, 4'h2, 4'h0);
    rst = 1'b0;
    step(0, 1, 4'h2, 4'h0);
    chk("R10 access ended by reset", {3'b0, outEn}, 4'h0);
    step(0, 0, 4'h2, 4'hF ^ patB(2));
    step(0, 0, 4'h2, 4'hF ^ patB(2));
    chk("R7 no write without edge", {3'b0, outEn}, 4'h0);
    step(1, 1, 4'h0, 4'h0);
    rdWord(2, patB(2), 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule